// File: doc/BRIEF.md
# Free-Running Sync Counter

The block is a read-only peripheral that counts pulses of a slow 32768 Hz reference. The reference reaches it as a tick enable that lasts one cycle of the fast system clock. Software reads the count through a small register bus that supports byte, half-word and word accesses. Two word locations are decoded: a fixed identification value and the running count.

A word read returns the whole count in one access. A bus master that can only move 16 bits reads the low half first. That read copies the upper half of the same register into a holding register. A later half-word read of the upper location returns the copy, so the two halves always belong to the same instant, even when a carry crosses bit 16 between the two reads. Writes, byte reads, reserved size codes, misaligned accesses and reads of unmapped locations are all refused: the read data is zero, a one-cycle error pulse is raised, and no internal state changes.

Top module: `syncc_timer`

## Requirements
- R1: The count increases by exactly one on each clock edge where `tick_i` is high, and keeps its value on every other edge.
- R2: After reset the count and the holding register are both zero, so a word read of the count and a half-word read of the upper count location both return 0.
- R3: A word read (size code 2) of word offset 0x00 returns the identification value 0x00000021.
- R4: A word read of word offset 0x10 returns the count, zero-extended to 32 bits, as it stood before any increment made on the same edge. The holding register is left unchanged.
- R5: A half-word read (size code 1) with address bit 1 clear and bit 0 clear returns bits 15:0 of the addressed register in bits 15:0 of the read data. On the same edge it stores bits 31:16 of that register in the holding register.
- R6: A half-word read with address bit 1 set and bit 0 clear returns the holding register in bits 15:0, not the live upper half of the count.
- R7: A byte read (size code 0) or a read with the reserved size code 3 returns zero, pulses `err_o`, and changes no state.
- R8: Any write returns zero and pulses `err_o`, whatever the address and data. The count keeps advancing with ticks as usual, and the holding register keeps its value.
- R9: A read is refused (zero data, `err_o` pulse) when its word offset is neither 0x00 nor 0x10, when a word read has address bits 1:0 not zero, or when a half-word read has address bit 0 set.
- R10: `rdata_o` and `err_o` are registered and give the response one cycle after the request edge. Without a request both are zero. `err_o` is never high together with nonzero read data.
- R11: The count wraps from all ones to zero with no flag or other side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle enable, one per period of the 32768 Hz reference |
| req_i | input | 1 | Access request strobe |
| wr_i | input | 1 | Write flag; 1 marks a write |
| addr_i | input | ADDR_W (12) | Byte address within the block |
| size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 reserved |
| wdata_i | input | 32 | Write data (always refused) |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Registered one-cycle error pulse |

## Verification
Two things can happen on the same edge: the count can increment, and a read can sample the count or capture its upper half. The bench lines up a tick with several reads. One is a word read. Another is a low-half read taken when the count sits at 0xFFFF, so that the same edge both captures the upper half and carries into it. The expected results are the pre-increment value: low half 0xFFFF and captured upper half 0. The next upper-half read must return that captured 0 while the live upper half has already become 1. A following word read must show the incremented count.

// File: rtl/syncc_pkg.sv
package syncc_pkg;

   localparam int unsigned BUS_W  = 32;
   localparam int unsigned HALF_W = 16;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   typedef enum logic [2:0] {
      ACC_IDLE,
      ACC_REJECT,
      ACC_FULL,
      ACC_LOWER,
      ACC_UPPER
   } acc_kind_e;

endpackage

// File: rtl/syncc_tick_counter.sv
module syncc_tick_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   output logic [CNT_W-1:0] count_o
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         count_q <= '0;
      else if (tick_i)
         count_q <= count_q + 1'b1;
   end

   assign count_o = count_q;

   // R1: one step per tick, otherwise still
   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> count_q == CNT_W'($past(count_q) + 1'b1));
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(count_q));
   // R11: silent wrap
   p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && (&count_q)) |=> count_q == '0);

endmodule

// File: rtl/syncc_access_decode.sv
module syncc_access_decode
   import syncc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] ID_OFFS  = '0,
   parameter logic [ADDR_W-1:0] CNT_OFFS = ADDR_W'(16)
) (
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   output acc_kind_e         kind_o,
   output logic              sel_cnt_o
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] word_idx;
   logic             hit_id;
   logic             hit_cnt;

   assign word_idx  = addr_i[ADDR_W-1:2];
   assign hit_id    = (word_idx == ID_OFFS[ADDR_W-1:2]);
   assign hit_cnt   = (word_idx == CNT_OFFS[ADDR_W-1:2]);
   assign sel_cnt_o = hit_cnt;

   always_comb begin
      kind_o = ACC_IDLE;
      if (req_i) begin
         if (wr_i || !(hit_id || hit_cnt)) begin
            kind_o = ACC_REJECT;
         end else begin
            unique case (size_i)
               SZ_WORD: kind_o = (addr_i[1:0] == 2'b00) ? ACC_FULL : ACC_REJECT;
               SZ_HALF: begin
                  if (addr_i[0])      kind_o = ACC_REJECT;
                  else if (addr_i[1]) kind_o = ACC_UPPER;
                  else                kind_o = ACC_LOWER;
               end
               default: kind_o = ACC_REJECT;
            endcase
         end
      end
   end

endmodule

// File: rtl/syncc_resp_path.sv
module syncc_resp_path
   import syncc_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter logic [BUS_W-1:0] ID_VALUE = 32'h21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  acc_kind_e        kind_i,
   input  logic             sel_cnt_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [BUS_W-1:0] rdata_o,
   output logic             err_o
);

   logic [BUS_W-1:0]  count_ext;
   logic [BUS_W-1:0]  reg_val;
   logic [HALF_W-1:0] hold_q;
   logic [BUS_W-1:0]  rdata_d;

   if (CNT_W == BUS_W) begin : g_full
      assign count_ext = count_i;
   end else begin : g_pad
      assign count_ext = {{(BUS_W-CNT_W){1'b0}}, count_i};
   end

   assign reg_val = sel_cnt_i ? count_ext : ID_VALUE;

   always_comb begin
      unique case (kind_i)
         ACC_FULL:  rdata_d = reg_val;
         ACC_LOWER: rdata_d = {{HALF_W{1'b0}}, reg_val[HALF_W-1:0]};
         ACC_UPPER: rdata_d = {{HALF_W{1'b0}}, hold_q};
         default:   rdata_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         rdata_o <= '0;
         err_o   <= 1'b0;
      end else begin
         rdata_o <= rdata_d;
         err_o   <= (kind_i == ACC_REJECT);
         if (kind_i == ACC_LOWER)
            hold_q <= reg_val[BUS_W-1:HALF_W];
      end
   end

   // R4 R7 R8: only a low-half read may touch the holding register
   p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i != ACC_LOWER) |=> $stable(hold_q));
   // R10: an error response carries no data
   p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> rdata_o == '0);
   // R10: no request, quiet outputs
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == ACC_IDLE) |=> (!err_o && rdata_o == '0));
   // R6: upper read echoes the held half
   p_upper_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == ACC_UPPER) |=> rdata_o == {{HALF_W{1'b0}}, $past(hold_q)});

endmodule

// File: rtl/syncc_timer.sv
module syncc_timer
   import syncc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned CNT_W    = 32,
   parameter logic [ADDR_W-1:0] ID_OFFS  = '0,
   parameter logic [ADDR_W-1:0] CNT_OFFS = ADDR_W'(16),
   parameter logic [31:0] ID_VALUE = 32'h21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              err_o
);

   if (CNT_W < HALF_W + 1 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("syncc_timer: CNT_W must lie in 17..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("syncc_timer: ADDR_W must be at least 5");
   end
   if (ID_OFFS[1:0] != 2'b00 || CNT_OFFS[1:0] != 2'b00 ||
       ID_OFFS[ADDR_W-1:2] == CNT_OFFS[ADDR_W-1:2]) begin : g_bad_map
      $error("syncc_timer: offsets must be distinct and word aligned");
   end

   acc_kind_e        kind;
   logic             sel_cnt;
   logic [CNT_W-1:0] count;

   syncc_tick_counter #(.CNT_W(CNT_W)) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .count_o (count)
   );

   syncc_access_decode #(
      .ADDR_W   (ADDR_W),
      .ID_OFFS  (ID_OFFS),
      .CNT_OFFS (CNT_OFFS)
   ) u_decode (
      .req_i     (req_i),
      .wr_i      (wr_i),
      .addr_i    (addr_i),
      .size_i    (size_i),
      .kind_o    (kind),
      .sel_cnt_o (sel_cnt)
   );

   syncc_resp_path #(
      .CNT_W    (CNT_W),
      .ID_VALUE (ID_VALUE)
   ) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind_i    (kind),
      .sel_cnt_i (sel_cnt),
      .count_i   (count),
      .rdata_o   (rdata_o),
      .err_o     (err_o)
   );

   // R8: writes are refused, whatever they carry
   p_write_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && wr_i && (wdata_i != 32'h0 || wdata_i == 32'h0)) |=> err_o);
   // R3: word read of the identification slot
   p_ident_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !wr_i && size_i == SZ_WORD && addr_i == ID_OFFS)
      |=> rdata_o == ID_VALUE);
   // R7: byte reads are refused
   p_byte_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && size_i == SZ_BYTE) |=> (err_o && rdata_o == 32'h0));

endmodule

// File: tb/syncc_timer_tb_top.sv
module syncc_timer_tb_top;

   localparam int unsigned ADDR_W = 12;
   localparam int unsigned CNT_W  = 17;
   localparam int unsigned CMASK  = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_i = 1'b0;
   logic              req_i = 1'b0;
   logic              wr_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [1:0]        size_i = 2'd0;
   logic [31:0]       wdata_i = '0;
   logic [31:0]       rdata_o;
   logic              err_o;

   always #5 clk = ~clk;

   syncc_timer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .req_i   (req_i),
      .wr_i    (wr_i),
      .addr_i  (addr_i),
      .size_i  (size_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata_o),
      .err_o   (err_o)
   );

   typedef struct {
      logic [31:0] data;
      logic        err;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_checks = 0;
   int          n_fail   = 0;
   int unsigned exp_cnt  = 0;
   bit          done     = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: one access, optionally with a tick on the same edge
   task automatic acc(input logic w, input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                      input logic tk, input logic [31:0] ed, input logic ee, input string tag);
      exp_t e;
      @(negedge clk);
      req_i = 1'b1; wr_i = w; addr_i = a; size_i = sz; tick_i = tk;
      wdata_i = w ? 32'hA5A5_5A5A : 32'h0;
      e.data = ed; e.err = ee; e.tag = tag;
      sb_q.push_back(e);
      if (tk) exp_cnt = (exp_cnt + 1) & CMASK;
      @(negedge clk);
      req_i = 1'b0; wr_i = 1'b0; tick_i = 1'b0;
   endtask

   task automatic ticks(input int unsigned n);
      @(negedge clk);
      tick_i = 1'b1;
      for (int unsigned i = 0; i < n; i++) begin
         exp_cnt = (exp_cnt + 1) & CMASK;
         if (i + 1 < n) @(negedge clk);
      end
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   // monitor: pop and compare after each request edge
   always begin
      @(posedge clk);
      if (rst_n && req_i) begin
         #2;
         if (sb_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R10: response with no expectation, actual %h expected none", rdata_o);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " data"}, rdata_o, e.data);
            check({e.tag, " err"}, {31'h0, err_o}, {31'h0, e.err});
         end
      end
   end

   initial begin
      #1_900_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 reset data", rdata_o, 32'h0);
      check("R10 reset err", {31'h0, err_o}, 32'h0);

      acc(0, 12'h010, 2'd2, 0, 32'h0, 0, "R2 count zero");
      acc(0, 12'h012, 2'd1, 0, 32'h0, 0, "R2 hold zero");
      acc(0, 12'h000, 2'd2, 0, 32'h21, 0, "R3 ident word");
      acc(0, 12'h000, 2'd1, 0, 32'h21, 0, "R5 ident low half");
      acc(0, 12'h002, 2'd1, 0, 32'h0, 0, "R6 ident upper held");

      ticks(5);
      acc(0, 12'h010, 2'd2, 0, 32'd5, 0, "R1 R4 count after 5");
      acc(0, 12'h010, 2'd2, 1, 32'd5, 0, "R4 pre-increment value");
      acc(0, 12'h010, 2'd2, 0, 32'd6, 0, "R1 count after same-edge tick");

      acc(0, 12'h010, 2'd0, 0, 32'h0, 1, "R7 byte read");
      acc(0, 12'h010, 2'd3, 0, 32'h0, 1, "R7 reserved size");
      acc(1, 12'h010, 2'd2, 1, 32'h0, 1, "R8 write count");
      acc(0, 12'h010, 2'd2, 0, 32'd7, 0, "R8 count still ticks");
      acc(0, 12'h004, 2'd2, 0, 32'h0, 1, "R9 unmapped 0x04");
      acc(0, 12'h020, 2'd2, 0, 32'h0, 1, "R9 unmapped 0x20");
      acc(0, 12'h011, 2'd1, 0, 32'h0, 1, "R9 odd half");
      acc(0, 12'h012, 2'd2, 0, 32'h0, 1, "R9 misaligned word");

      ticks(32'hFFFF - exp_cnt);
      acc(0, 12'h010, 2'd1, 1, 32'h0000_FFFF, 0, "R5 low half with carry");
      acc(0, 12'h012, 2'd1, 0, 32'h0, 0, "R6 held not live");
      acc(0, 12'h010, 2'd2, 0, 32'h0001_0000, 0, "R4 live after carry");
      acc(0, 12'h012, 2'd1, 0, 32'h0, 0, "R4 word leaves hold");
      acc(0, 12'h010, 2'd1, 0, 32'h0, 0, "R5 low half capture");
      acc(1, 12'h012, 2'd1, 0, 32'h0, 1, "R8 write upper");
      acc(0, 12'h012, 2'd1, 0, 32'h1, 0, "R8 hold untouched");
      acc(0, 12'h012, 2'd0, 0, 32'h0, 1, "R7 byte upper");
      acc(0, 12'h012, 2'd1, 0, 32'h1, 0, "R7 hold untouched");

      ticks(CMASK - exp_cnt);
      acc(0, 12'h010, 2'd2, 0, 32'h0001_FFFF, 0, "R11 all ones");
      ticks(1);
      acc(0, 12'h010, 2'd2, 0, 32'h0, 0, "R11 wrapped to zero");

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL R10: actual %0d pending expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule